// File: doc/BRIEF.md
# DMA Event Flag and Interrupt Bank

This block holds the sticky event flags of eight DMA streams. Every stream reports five kinds of event as one-cycle set pulses: FIFO error, direct-mode error, transfer error, half transfer and transfer complete. Each pulse sets a flag, and the flag stays set until software clears it. Software reads the flags as two packed 32-bit status words through a simple read port. It clears them by writing ones to two separate clear words.

Each stream also has a five-bit enable vector. The block drives one registered interrupt line per stream. That line is high while any of the stream's flags is set and also enabled.

Address decode, bit packing and clear priority are handled inside the block. Bus bridging and the event sources sit outside it.

Top module: `dmaflg_bank`

## Requirements
- R1: After reset every flag is clear, every interrupt line is low, `rd_valid` is low, and reads of both status words return zero.
- R2: A one-cycle set pulse on an event input sets that stream's flag at the next clock edge. The flag then stays set, with no further pulses, until it is cleared.
- R3: The status word at byte address 0x0 holds streams 0, 1, 2 and 3, in 6-bit groups starting at bits 0, 6, 16 and 22. Inside a group, FIFO error is at bit 0, direct-mode error at bit 2, transfer error at bit 3, half transfer at bit 4 and transfer complete at bit 5.
- R4: The status word at byte address 0x4 holds streams 4, 5, 6 and 7, with the same group offsets and bit layout as R3.
- R5: A write to 0x8 (for streams 0 to 3) or to 0xC (for streams 4 to 7) clears each flag whose bit, at the R3 position, is one in the written data. Zero bits leave their flags unchanged.
- R6: When a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: Bit 1 of every group, bits 12 to 15 and bits 28 to 31 always read as zero. Reads of 0x8, 0xC and any other address return zero.
- R8: Writes to the status addresses 0x0 and 0x4 change no flag.
- R9: A stream's interrupt line is the OR of its flags, each ANDed with its enable bit. The line is registered, so it follows flags and enables one clock edge later. Enable vector bits for stream s sit at `irq_en[5s+k]`: k=0 FIFO error, k=1 direct-mode error, k=2 transfer error, k=3 half transfer, k=4 transfer complete.
- R10: A read issued with `rd_en` in one cycle returns its data with `rd_valid` high after the next clock edge. The data reflects the flags as they stood before that edge. `rd_valid` is low in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_fifo_err | input | NUM_STREAMS | FIFO error set pulses, one bit per stream |
| evt_dm_err | input | NUM_STREAMS | Direct-mode error set pulses |
| evt_xfer_err | input | NUM_STREAMS | Transfer error set pulses |
| evt_half | input | NUM_STREAMS | Half transfer set pulses |
| evt_done | input | NUM_STREAMS | Transfer complete set pulses |
| irq_en | input | 5*NUM_STREAMS | Per-stream interrupt enables, layout in R9 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| irq | output | NUM_STREAMS | Interrupt line per stream |

## Verification
The bench targets the gapped packing. It drives single events on every stream and then reads both words. A design with a wrong offset, a missing 4-bit gap, or streams swapped between words would show flags at the wrong bits, or reserved bits set.

It collides a set pulse with a clearing write on the same flag. A design that gives clear priority would silently drop that event.

It writes all ones to the status addresses, and writes clear words with sparse masks. A design that decodes status writes as clears, or clears on zero bits, would lose flags.

It also walks each enable bit on its own. A swapped enable position would raise or miss an interrupt on the wrong event.

// File: rtl/dmaflg_pkg.sv
package dmaflg_pkg;

    // Five event kinds per stream, in enable-vector order.
    localparam int EVT_N          = 5;
    localparam int EV_FIFO        = 0;
    localparam int EV_DIRECT      = 1;
    localparam int EV_XFER        = 2;
    localparam int EV_HALF        = 3;
    localparam int EV_DONE        = 4;

    // Packing of streams into status words.
    localparam int SLOTS_PER_WORD = 4;
    localparam int GROUP_W        = 6;

    // Start bit of a stream's group inside its word: 0, 6, 16, 22.
    function automatic int grp_base(input int slot);
        return slot * GROUP_W + ((slot >= 2) ? 4 : 0);
    endfunction

    // Bit inside a group for an event kind; bit 1 stays reserved.
    function automatic int evt_bit(input int ev);
        return (ev == EV_FIFO) ? 0 : ev + 1;
    endfunction

    // Every bit that a status word can ever drive to one.
    function automatic logic [31:0] live_mask();
        logic [31:0] m;
        m = '0;
        for (int s = 0; s < SLOTS_PER_WORD; s++) begin
            for (int e = 0; e < EVT_N; e++) begin
                m[grp_base(s) + evt_bit(e)] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/dmaflg_stream.sv
module dmaflg_stream
    import dmaflg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] set_i,
    input  logic [EVT_N-1:0] clr_i,
    input  logic [EVT_N-1:0] ie_i,
    output logic [EVT_N-1:0] flag_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [EVT_N-1:0] flags;
        logic             irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A set in the same cycle as a clear wins.
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
        st_d.irq   = |(st_d.flags & ie_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flags;
    assign irq_o  = st_q.irq;

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));

    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i)) |=> ((flag_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(flag_o));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|flag_o));

endmodule

// File: rtl/dmaflg_regport.sv
module dmaflg_regport
    import dmaflg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NUM_STREAMS*EVT_N-1:0] flags_i,
    output logic [NUM_STREAMS*EVT_N-1:0] clr_o,
    output logic                         rd_valid_o,
    output logic [DATA_W-1:0]            rd_data_o
);

    localparam int NUM_WORDS = (NUM_STREAMS + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD;
    localparam logic [31:0] LIVE = live_mask();
    localparam logic [DATA_W-1:0] LIVE_W = DATA_W'(LIVE);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] stat_w [NUM_WORDS];
    logic [NUM_WORDS-1:0] clr_hit;
    logic [NUM_WORDS-1:0] stat_hit;
    logic unused_wr_bits;

    // Pack the flags into their status words.
    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            stat_w[w] = '0;
        end
        for (int s = 0; s < NUM_STREAMS; s++) begin
            for (int e = 0; e < EVT_N; e++) begin
                stat_w[s / SLOTS_PER_WORD][grp_base(s % SLOTS_PER_WORD) + evt_bit(e)]
                    = flags_i[s*EVT_N + e];
            end
        end
    end

    // Decode writes to the clear words (status words sit below them).
    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            clr_hit[w]  = wr_en && (wr_addr == ADDR_W'(4 * (NUM_WORDS + w)));
            stat_hit[w] = wr_en && (wr_addr == ADDR_W'(4 * w));
        end
        for (int s = 0; s < NUM_STREAMS; s++) begin
            for (int e = 0; e < EVT_N; e++) begin
                clr_o[s*EVT_N + e] = clr_hit[s / SLOTS_PER_WORD]
                    && wr_data[grp_base(s % SLOTS_PER_WORD) + evt_bit(e)];
            end
        end
    end

    assign unused_wr_bits = ^(wr_data & ~LIVE_W);

    // Registered read: status words decode, everything else reads zero.
    always_comb begin
        rd_d       = '0;
        rd_d.valid = rd_en;
        if (rd_en) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (rd_addr == ADDR_W'(4 * w)) begin
                    rd_d.data = stat_w[w];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_data_o  = rd_q.data;

    p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid_o);

    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid_o);

    p_dead_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ((rd_data_o & ~LIVE_W) == '0));

    p_status_write_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_hit) |-> (clr_o == '0));

endmodule

// File: rtl/dmaflg_bank.sv
module dmaflg_bank
    import dmaflg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STREAMS-1:0]       evt_fifo_err,
    input  logic [NUM_STREAMS-1:0]       evt_dm_err,
    input  logic [NUM_STREAMS-1:0]       evt_xfer_err,
    input  logic [NUM_STREAMS-1:0]       evt_half,
    input  logic [NUM_STREAMS-1:0]       evt_done,
    input  logic [NUM_STREAMS*EVT_N-1:0] irq_en,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_STREAMS-1:0]       irq
);

    logic [NUM_STREAMS*EVT_N-1:0] flags;
    logic [NUM_STREAMS*EVT_N-1:0] clr;

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        logic [EVT_N-1:0] set_v;
        assign set_v[EV_FIFO]   = evt_fifo_err[s];
        assign set_v[EV_DIRECT] = evt_dm_err[s];
        assign set_v[EV_XFER]   = evt_xfer_err[s];
        assign set_v[EV_HALF]   = evt_half[s];
        assign set_v[EV_DONE]   = evt_done[s];

        dmaflg_stream u_stream (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v),
            .clr_i  (clr[s*EVT_N +: EVT_N]),
            .ie_i   (irq_en[s*EVT_N +: EVT_N]),
            .flag_o (flags[s*EVT_N +: EVT_N]),
            .irq_o  (irq[s])
        );
    end

    dmaflg_regport #(
        .NUM_STREAMS (NUM_STREAMS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W)
    ) u_regport (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .flags_i    (flags),
        .clr_o      (clr),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    p_irq_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |=> (irq == '0));

endmodule

// File: tb/tb_dmaflg_bank.sv
`timescale 1ns/100ps
module tb_dmaflg_bank;

    localparam int NS = 8;
    localparam int NE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS*NE-1:0] set_v = '0;
    logic [NS*NE-1:0] en_v = '0;
    logic [NS-1:0] e_fifo, e_dm, e_xfer, e_half, e_done;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic [NS-1:0] irq;

    int checks = 0, fails = 0;
    logic [NE-1:0] model [NS];
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            e_fifo[s] = set_v[s*NE+0];
            e_dm[s]   = set_v[s*NE+1];
            e_xfer[s] = set_v[s*NE+2];
            e_half[s] = set_v[s*NE+3];
            e_done[s] = set_v[s*NE+4];
        end
    end

    dmaflg_bank dut (
        .clk(clk), .rst_n(rst_n),
        .evt_fifo_err(e_fifo), .evt_dm_err(e_dm), .evt_xfer_err(e_xfer),
        .evt_half(e_half), .evt_done(e_done), .irq_en(en_v),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    // Independent layout tables taken from R3.
    function automatic int off_of(input int slot);
        case (slot)
            0: return 0;
            1: return 6;
            2: return 16;
            default: return 22;
        endcase
    endfunction

    function automatic int pos_of(input int ev);
        case (ev)
            0: return 0;
            1: return 2;
            2: return 3;
            3: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [31:0] pack_word(input int w);
        logic [31:0] r = '0;
        for (int sl = 0; sl < 4; sl++)
            for (int e = 0; e < NE; e++)
                r[off_of(sl) + pos_of(e)] = model[w*4+sl][e];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if (a == 4'h0) return pack_word(0);
        if (a == 4'h4) return pack_word(1);
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, starting and ending on a falling edge.
    task automatic cyc(input logic [NS*NE-1:0] set, input logic wr, input logic [3:0] wa,
                       input logic [31:0] wd, input logic rd, input logic [3:0] ra,
                       input string tag);
        logic [NE-1:0] clr [NS];
        logic [NS-1:0] exp_irq;
        set_v = set; wr_en = wr; wr_addr = wa; wr_data = wd; rd_en = rd; rd_addr = ra;
        if (rd) begin
            exp_q.push_back(exp_read(ra));
            tag_q.push_back(tag);
        end
        for (int s = 0; s < NS; s++)
            for (int e = 0; e < NE; e++)
                clr[s][e] = wr && (wa == 4'(8 + 4*(s/4))) && wd[off_of(s%4) + pos_of(e)];
        @(posedge clk);
        for (int s = 0; s < NS; s++)
            model[s] = (model[s] & ~clr[s]) | set[s*NE +: NE];
        @(negedge clk);
        set_v = '0; wr_en = 1'b0; rd_en = 1'b0;
        for (int s = 0; s < NS; s++)
            exp_irq[s] = |(model[s] & en_v[s*NE +: NE]);
        check("R9 irq", 32'(irq), 32'(exp_irq));
        check("R10 rd_valid", 32'(rd_valid), 32'(rd));
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc('0, 1'b0, 4'h0, 32'h0, 1'b1, a, tag);
    endtask

    task automatic idle();
        cyc('0, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "idle");
    endtask

    // Monitor: pops the scoreboard whenever the design presents read data.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10: unexpected read data %h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [NS*NE-1:0] v;
        for (int s = 0; s < NS; s++) model[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq at reset", 32'(irq), 32'h0);
        check("R1 rd_valid at reset", 32'(rd_valid), 32'h0);
        rst_n = 1'b1;
        rd(4'h0, "R1 low word after reset");
        rd(4'h4, "R1 high word after reset");

        // R2/R3: each event of stream 0, then sticky with no pulses.
        for (int e = 0; e < NE; e++) begin
            v = '0; v[e] = 1'b1;
            cyc(v, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "R2");
            rd(4'h0, "R3 stream0 event");
        end
        idle(); idle();
        rd(4'h0, "R2 flags sticky");
        // R5: clear all of low word.
        cyc('0, 1'b1, 4'h8, 32'hFFFF_FFFF, 1'b1, 4'h0, "R5 read before clear");
        rd(4'h0, "R5 low cleared");

        // R3: streams 1..3 with distinct events.
        cyc({{(NS*NE-20){1'b0}}, 5'b10000, 5'b00010, 5'b01001, 5'b00000}, 1'b0, 4'h0, 32'h0,
            1'b0, 4'h0, "R3");
        rd(4'h0, "R3 streams 1-3 offsets");
        rd(4'h4, "R4 high untouched by low streams");

        // R4: streams 4..7.
        v = '0;
        v[4*NE+0] = 1'b1; v[5*NE+4] = 1'b1; v[6*NE+2] = 1'b1; v[7*NE+3] = 1'b1; v[7*NE+1] = 1'b1;
        cyc(v, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "R4");
        rd(4'h4, "R4 streams 4-7 offsets");

        // R5: sparse clear masks; zero bits must not clear.
        cyc('0, 1'b1, 4'hC, 32'h0020_0000, 1'b0, 4'h0, "R5");
        rd(4'h4, "R5 sparse high clear");
        cyc('0, 1'b1, 4'h8, 32'h0000_0000, 1'b0, 4'h0, "R5");
        rd(4'h0, "R5 zero write no effect");

        // R8: all-ones written to status words.
        cyc('0, 1'b1, 4'h0, 32'hFFFF_FFFF, 1'b0, 4'h0, "R8");
        cyc('0, 1'b1, 4'h4, 32'hFFFF_FFFF, 1'b0, 4'h0, "R8");
        rd(4'h0, "R8 low after status write");
        rd(4'h4, "R8 high after status write");

        // R7: every flag set; dead bits and other addresses read zero.
        cyc('1, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "R7");
        rd(4'h0, "R7 low all set");
        rd(4'h4, "R7 high all set");
        rd(4'h8, "R7 clear word reads zero");
        rd(4'hC, "R7 clear word reads zero");
        rd(4'h2, "R7 unmapped address");

        // R6: set and clear collide on every flag of both words.
        cyc('1, 1'b1, 4'h8, 32'hFFFF_FFFF, 1'b0, 4'h0, "R6");
        rd(4'h0, "R6 set wins low");
        cyc('0, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 4'h0, "R5");
        v = '0; v[6*NE+4] = 1'b1;
        cyc(v, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 4'h0, "R6");
        rd(4'h4, "R6 set wins high");

        // R9: walk each enable bit for stream 6 and stream 1.
        cyc('0, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 4'h0, "R9");
        for (int e = 0; e < NE; e++) begin
            v = '0; v[6*NE+e] = 1'b1; v[1*NE+((e+1)%NE)] = 1'b1;
            cyc(v, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "R9");
            en_v = '0; en_v[6*NE+e] = 1'b1; en_v[1*NE+e] = 1'b1;
            idle(); idle();
            en_v = '0; en_v[6*NE+((e+2)%NE)] = 1'b1;
            idle();
            cyc('0, 1'b1, 4'h8, 32'hFFFF_FFFF, 1'b0, 4'h0, "R9");
            cyc('0, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 4'h0, "R9");
        end
        en_v = '1;
        cyc('1, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "R9 all");

        // R10: back-to-back reads.
        rd(4'h0, "R10 b2b first");
        rd(4'h4, "R10 b2b second");
        rd(4'h0, "R10 b2b third");
        idle(); idle();
        check("R10 queue drained", 32'(exp_q.size()), 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule